// File: doc/BRIEF.md
# Multi-Lane Phase and Word Deskew Trainer

This block lines up the serial data of several converter lanes that reach the receiver with different delays. Every lane is sampled at a set of evenly spaced clock phases inside one bit period, so the block sees one sample bit per phase per lane on each clock. On a start command each lane trains on its own. It sweeps the phases one after another and scores each phase against a repeating 16-bit training word that the converter sends while in test mode. It settles on the phase in the middle of the widest stretch of clean phases. It then finds the bit shift, within three bits either side of nominal, that puts the training word on the word boundary.

After training, a lane keeps its phase and shift fixed. It delivers one aligned word per boundary, and all lanes deliver on the same boundary clock. A lane with no clean phase, or with a shift outside the allowed span, raises its error flag instead of its lock flag. A global done flag rises once every lane has either locked or failed.

Top module: `deskew_train`

## Requirements
- R1: A free-running bit counter starts at reset release and marks a word boundary on clock 16j+15, where clock 0 is the first rising edge after reset release. `out_valid` pulses only in the clock after a boundary, so consecutive pulses are exactly 16 clocks apart. The sample of phase p on lane L is `taps[L*8+p]`.
- R2: A `start` pulse sends every lane through phases 0,1,...,7 in ascending order. After each phase change two words are discarded, then 64 words are scored. A phase passes only if all 64 scored words equal some rotation of the training word 16'hF0B2.
- R3: The chosen phase is the centre of the longest run of passing phases, counted circularly from 7 back to 0. For a run that starts at s with length n, the centre is (s+(n-1)/2) mod 8. When two runs are equally long, the run with the lowest start wins. When all eight phases pass, phase 3 is chosen.
- R4: A lane has offset d when the MSB of every training word is sampled on the clocks p where (p+d) mod 16 = 13. After two settling words at the chosen phase, the lane looks for its offset in the order -3 to +3 and locks on the first one that reproduces 16'hF0B2 exactly.
- R5: A lane on which no phase passes raises `lane_err` and keeps `lane_lock` low.
- R6: A lane whose offset lies outside -3..+3 raises `lane_err` and keeps `lane_lock` low.
- R7: While `all_done` is high, the word a locked lane shows after boundary clock 16j+15 is made of the bits sampled at clocks 16j-3-d through 16j+12-d, with the earliest bit as MSB. Every lane produces on the same boundary. A lane in error shows zero.
- R8: `all_done` is high exactly when every lane is locked or in error. A `start` clears all lock and error flags, which keeps `all_done` low while training runs.
- R9: Once a lane is locked, its phase and shift do not change until the next `start`, and samples taken on the other phases have no effect on its output.
- R10: After reset every output is zero and the lanes stay idle until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock pulse that begins (or restarts) training on all lanes |
| taps | input | LANES*PHASES | One sample per phase per lane, lane L phase p at bit L*PHASES+p |
| out_data | output | LANES*WORD_W | Aligned words, lane L in bits L*WORD_W upward |
| out_valid | output | 1 | Pulses in the clock after each boundary while all_done is high |
| lane_lock | output | LANES | Lane trained successfully |
| lane_err | output | LANES | Lane training failed |
| all_done | output | 1 | Every lane locked or failed |

## Verification
If a lane holds a wrong phase index, samples from a noisy phase reach its output and corrupt the very first word after `all_done`. If it holds a wrong shift count, every word it delivers is rotated. Either fault shows at the ports within 32 clocks of training ending. A fault in the sweep scoring or in the centre choice shows as a lock or error flag that does not match the configured window, and that is read as soon as `all_done` rises. A wrong boundary counter moves every `out_valid` pulse away from the 16-clock grid the bench computes on its own.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
   typedef enum logic [2:0] {
      LS_IDLE,
      LS_SWEEP,
      LS_PICK,
      LS_SLIP,
      LS_LOCK,
      LS_FAIL
   } lane_state_e;
endpackage

// File: rtl/deskew_word_timer.sv
module deskew_word_timer #(
   parameter int WORD_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic word_end
);
   localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [CW-1:0] bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               bit_cnt <= '0;
      else if (bit_cnt == LAST) bit_cnt <= '0;
      else                      bit_cnt <= bit_cnt + 1'b1;
   end

   assign word_end = (bit_cnt == LAST);

   // R1: boundaries never fall on adjacent clocks
   a_r1_boundary_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |=> !word_end);
endmodule

// File: rtl/deskew_match.sv
module deskew_match #(
   parameter int                WORD_W   = 16,
   parameter int                MAX_SLIP = 3,
   parameter logic [WORD_W-1:0] PATTERN  = 16'hF0B2,
   parameter int                SLIP_W   = $clog2(2*MAX_SLIP+1)
) (
   input  logic [WORD_W+2*MAX_SLIP-1:0] win,
   output logic                         rot_hit,
   output logic                         slip_hit,
   output logic [SLIP_W-1:0]            slip_idx
);
   localparam int NCAND = 2*MAX_SLIP + 1;
   localparam logic [2*WORD_W-1:0] DBL = {PATTERN, PATTERN};

   logic [WORD_W-1:0] rot_vec;
   logic [NCAND-1:0]  cand_vec;

   for (genvar r = 0; r < WORD_W; r++) begin : g_rot
      assign rot_vec[r] = (win[WORD_W-1:0] == DBL[r +: WORD_W]);
   end

   for (genvar k = 0; k < NCAND; k++) begin : g_cand
      assign cand_vec[k] = (win[k +: WORD_W] == PATTERN);
   end

   assign rot_hit  = |rot_vec;
   assign slip_hit = |cand_vec;

   always_comb begin
      slip_idx = '0;
      for (int k = NCAND-1; k >= 0; k--) begin
         if (cand_vec[k]) slip_idx = SLIP_W'(k);
      end
   end
endmodule

// File: rtl/deskew_lane.sv
module deskew_lane
   import deskew_pkg::*;
#(
   parameter int                PHASES    = 8,
   parameter int                WORD_W    = 16,
   parameter int                WIN_WORDS = 64,
   parameter int                MAX_SLIP  = 3,
   parameter int                SETTLE    = 2,
   parameter logic [WORD_W-1:0] PATTERN   = 16'hF0B2,
   parameter int                PH_W      = $clog2(PHASES),
   parameter int                SLIP_W    = $clog2(2*MAX_SLIP+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              word_end,
   input  logic [PHASES-1:0] taps,
   output logic [WORD_W-1:0] word_o,
   output logic              lock_o,
   output logic              err_o
);
   localparam int WIN_LEN = WORD_W + 2*MAX_SLIP;
   localparam int HIST_W  = WIN_LEN - 1;
   localparam int CNT_W   = $clog2(WIN_WORDS + 1);
   localparam int SET_W   = $clog2(SETTLE + 1);

   lane_state_e       st;
   logic [PH_W-1:0]   phase_sel;
   logic [PHASES-1:0] pass_mask;
   logic [SET_W-1:0]  settle;
   logic [CNT_W-1:0]  wcnt, hits, hits_n;
   logic [SLIP_W-1:0] slip_k, slip_idx;
   logic [HIST_W-1:0] hist;
   logic [WIN_LEN-1:0] win;
   logic [WORD_W-1:0] word_q;
   logic              rot_hit, slip_hit;

   function automatic logic [PH_W-1:0] centre_of(input logic [PHASES-1:0] m);
      int best_len = 0;
      int best_c   = 0;
      for (int s = 0; s < PHASES; s++) begin
         int len = 0;
         bit run = 1'b1;
         for (int i = 0; i < PHASES; i++) begin
            if (run && m[(s+i) % PHASES]) len++;
            else                          run = 1'b0;
         end
         if (m[s] && (!m[(s+PHASES-1) % PHASES] || (&m && s == 0)) && len > best_len) begin
            best_len = len;
            best_c   = (s + (len-1)/2) % PHASES;
         end
      end
      return PH_W'(best_c);
   endfunction

   assign win    = {hist, taps[phase_sel]};
   assign hits_n = hits + CNT_W'(rot_hit);

   deskew_match #(
      .WORD_W(WORD_W), .MAX_SLIP(MAX_SLIP), .PATTERN(PATTERN), .SLIP_W(SLIP_W)
   ) u_match (
      .win(win), .rot_hit(rot_hit), .slip_hit(slip_hit), .slip_idx(slip_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= win[HIST_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= LS_IDLE;  phase_sel <= '0; pass_mask <= '0; settle <= '0;
         wcnt <= '0;     hits <= '0;      slip_k <= '0;    word_q <= '0;
      end else if (start) begin
         st <= LS_SWEEP; phase_sel <= '0; pass_mask <= '0; settle <= '0;
         wcnt <= '0;     hits <= '0;      slip_k <= '0;    word_q <= '0;
      end else begin
         unique case (st)
            LS_SWEEP: if (word_end) begin
               if (settle != SET_W'(SETTLE)) settle <= settle + 1'b1;
               else if (wcnt == CNT_W'(WIN_WORDS-1)) begin
                  pass_mask[phase_sel] <= (hits_n == CNT_W'(WIN_WORDS));
                  wcnt <= '0; hits <= '0; settle <= '0;
                  if (phase_sel == PH_W'(PHASES-1)) st <= LS_PICK;
                  else                              phase_sel <= phase_sel + 1'b1;
               end else begin
                  wcnt <= wcnt + 1'b1;
                  hits <= hits_n;
               end
            end
            LS_PICK: begin
               settle <= '0;
               if (pass_mask == '0) st <= LS_FAIL;
               else begin
                  phase_sel <= centre_of(pass_mask);
                  st        <= LS_SLIP;
               end
            end
            LS_SLIP: if (word_end) begin
               if (settle != SET_W'(SETTLE)) settle <= settle + 1'b1;
               else if (slip_hit) begin
                  slip_k <= slip_idx;
                  st     <= LS_LOCK;
               end else st <= LS_FAIL;
            end
            LS_LOCK: if (word_end) word_q <= win[slip_k +: WORD_W];
            default: ;
         endcase
      end
   end

   assign word_o = word_q;
   assign lock_o = (st == LS_LOCK);
   assign err_o  = (st == LS_FAIL);

   // R2: inside one sweep the phase only steps upward by one
   a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_SWEEP && $past(st) == LS_SWEEP && !$past(start) && phase_sel != $past(phase_sel))
      |-> phase_sel == $past(phase_sel) + 1'b1);
   // R4: lock is entered only from the shift search on a boundary
   a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> ($past(st) == LS_SLIP && $past(word_end)));
   // R9: locked settings stay frozen until a new start
   a_r9_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_LOCK && !start) |=> ($stable(phase_sel) && $stable(slip_k)));
   // R7: a failed lane never shows data
   a_r7_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (word_o == '0));
endmodule

// File: rtl/deskew_train.sv
module deskew_train #(
   parameter int                LANES     = 4,
   parameter int                PHASES    = 8,
   parameter int                WORD_W    = 16,
   parameter int                WIN_WORDS = 64,
   parameter int                MAX_SLIP  = 3,
   parameter int                SETTLE    = 2,
   parameter logic [WORD_W-1:0] PATTERN   = 16'hF0B2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [LANES*PHASES-1:0]  taps,
   output logic [LANES*WORD_W-1:0]  out_data,
   output logic                     out_valid,
   output logic [LANES-1:0]         lane_lock,
   output logic [LANES-1:0]         lane_err,
   output logic                     all_done
);
   localparam int PH_W   = $clog2(PHASES);
   localparam int SLIP_W = $clog2(2*MAX_SLIP + 1);

   if (PHASES < 2 || (PHASES & (PHASES-1)) != 0) begin : g_bad_phases
      $error("PHASES must be a power of two of at least 2");
   end
   if (MAX_SLIP < 1 || 2*MAX_SLIP >= WORD_W) begin : g_bad_slip
      $error("MAX_SLIP must lie in 1 .. WORD_W/2-1");
   end
   if (LANES < 1 || WIN_WORDS < 1 || SETTLE < 1) begin : g_bad_counts
      $error("LANES, WIN_WORDS and SETTLE must be positive");
   end

   logic word_end;
   logic valid_q;

   deskew_word_timer #(.WORD_W(WORD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .word_end(word_end)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      deskew_lane #(
         .PHASES(PHASES), .WORD_W(WORD_W), .WIN_WORDS(WIN_WORDS),
         .MAX_SLIP(MAX_SLIP), .SETTLE(SETTLE), .PATTERN(PATTERN),
         .PH_W(PH_W), .SLIP_W(SLIP_W)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .start(start), .word_end(word_end),
         .taps(taps[l*PHASES +: PHASES]),
         .word_o(out_data[l*WORD_W +: WORD_W]),
         .lock_o(lane_lock[l]), .err_o(lane_err[l])
      );
   end

   assign all_done = &(lane_lock | lane_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= word_end && all_done;
   end
   assign out_valid = valid_q;

   // R8: data is only announced after every lane has finished
   a_r8_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(all_done));
endmodule

// File: tb/deskew_train_bench.sv
module deskew_train_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int L_N = 4;
   localparam int P_N = 8;
   localparam logic [15:0] PAT = 16'hF0B2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [L_N*P_N-1:0] taps = '0;
   logic [L_N*16-1:0] out_data;
   logic out_valid;
   logic [L_N-1:0] lane_lock, lane_err;
   logic all_done;

   deskew_train u_deskew_train (
      .clk(clk), .rst_n(rst_n), .start(start), .taps(taps),
      .out_data(out_data), .out_valid(out_valid),
      .lane_lock(lane_lock), .lane_err(lane_err), .all_done(all_done)
   );

   always #10 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int pc = 0;
   int data_from = 1000000;
   int last_valid = -1;
   bit data_mode = 1'b0;
   bit run_data = 1'b0;
   logic [31:0] rs = 32'h1234_5678;
   logic [7:0] cfg_pass[L_N];
   int cfg_d[L_N];
   int exp_ph[L_N];
   bit exp_lk[L_N];
   logic [L_N*16-1:0] exp_q[$];

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] dat_word(input int lane, input int idx);
      logic [31:0] h;
      h = (idx * 32'h9E37_79B1) ^ ((lane + 1) * 32'h85EB_CA6B);
      return h[31:16] ^ h[15:0];
   endfunction

   function automatic logic [15:0] word_at(input int lane, input int idx);
      return (idx < data_from) ? PAT : dat_word(lane, idx);
   endfunction

   always @(posedge clk) if (rst_n) pc <= pc + 1;

   // monitor, scoreboard driver and tap stimulus, all away from the rising edge
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (last_valid >= 0)
            check(pc - last_valid == 16, "R1 valid spacing", 64'(pc - last_valid), 64'd16);
         last_valid = pc;
         if (exp_q.size() > 0) begin
            logic [L_N*16-1:0] e;
            e = exp_q.pop_front();
            for (int l = 0; l < L_N; l++)
               check(out_data[l*16 +: 16] == e[l*16 +: 16], "R4 R7 R9 aligned word",
                     64'(out_data[l*16 +: 16]), 64'(e[l*16 +: 16]));
         end else if (run_data) begin
            check(1'b0, "R7 unexpected valid", 64'd1, 64'd0);
         end
      end
      if (run_data && all_done && (pc % 16 == 15)) begin
         logic [L_N*16-1:0] e;
         int idx;
         idx = (pc - 15) / 16 - 1;
         for (int l = 0; l < L_N; l++)
            e[l*16 +: 16] = exp_lk[l] ? word_at(l, idx) : 16'h0;
         exp_q.push_back(e);
      end
      for (int l = 0; l < L_N; l++) begin
         int q, qm, qi;
         logic [15:0] w;
         q  = pc - 13 + cfg_d[l];
         qm = ((q % 16) + 16) % 16;
         qi = (q - qm) / 16;
         w  = word_at(l, qi);
         for (int p = 0; p < P_N; p++) begin
            bit good;
            good = data_mode ? (p == exp_ph[l]) : cfg_pass[l][p];
            rs = rs ^ (rs << 13);
            rs = rs ^ (rs >> 17);
            rs = rs ^ (rs << 5);
            taps[l*P_N + p] = good ? w[15 - qm] : rs[0];
         end
      end
   end

   task automatic train_run();
      int n;
      @(posedge clk); #5;
      data_mode = 1'b0;
      start = 1'b1;
      data_from = (pc + 9400) / 16;
      last_valid = -1;
      @(posedge clk); #5;
      start = 1'b0;
      repeat (40) @(posedge clk);
      #5;
      check(all_done == 1'b0, "R8 done low while training", 64'(all_done), 64'd0);
      check(lane_lock == '0, "R8 locks cleared by start", 64'(lane_lock), 64'd0);
      n = 0;
      while (!all_done && n < 20000) begin
         @(posedge clk); #5;
         n++;
      end
      check(all_done == 1'b1, "R8 done after training", 64'(all_done), 64'd1);
      for (int l = 0; l < L_N; l++) begin
         string msg;
         msg = exp_lk[l] ? "R2 R3 R4 lane locks" : (cfg_pass[l] == 8'h00 ? "R5 no clean phase" : "R6 shift out of span");
         check(lane_lock[l] == exp_lk[l], msg, 64'(lane_lock[l]), 64'(exp_lk[l]));
         check(lane_err[l] == !exp_lk[l], msg, 64'(lane_err[l]), 64'(!exp_lk[l]));
      end
      data_mode = 1'b1;
      run_data = 1'b1;
      while (pc < (data_from + 40) * 16 + 40) @(posedge clk);
      #5;
      run_data = 1'b0;
      repeat (40) @(posedge clk);
      #5;
      check(exp_q.size() == 0, "R7 every boundary delivered", 64'(exp_q.size()), 64'd0);
      exp_q.delete();
   endtask

   initial begin
      for (int l = 0; l < L_N; l++) begin
         cfg_pass[l] = 8'h00; cfg_d[l] = 0; exp_ph[l] = 0; exp_lk[l] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      repeat (20) @(posedge clk);
      #5;
      // R10: quiet after reset, idle without start
      check(lane_lock == '0, "R10 lock after reset", 64'(lane_lock), 64'd0);
      check(lane_err == '0, "R10 err after reset", 64'(lane_err), 64'd0);
      check(all_done == 1'b0, "R10 done after reset", 64'(all_done), 64'd0);
      check(out_valid == 1'b0, "R10 valid after reset", 64'(out_valid), 64'd0);
      check(out_data == '0, "R10 data after reset", 64'(out_data), 64'd0);

      // first run: centred windows, wrap-around run, split runs, offsets -3 and +3
      cfg_pass[0] = 8'b0001_1100; cfg_d[0] = 0;  exp_ph[0] = 3; exp_lk[0] = 1'b1;
      cfg_pass[1] = 8'b1000_0011; cfg_d[1] = -3; exp_ph[1] = 0; exp_lk[1] = 1'b1;
      cfg_pass[2] = 8'b0001_1110; cfg_d[2] = 3;  exp_ph[2] = 2; exp_lk[2] = 1'b1;
      cfg_pass[3] = 8'b0111_0001; cfg_d[3] = -1; exp_ph[3] = 5; exp_lk[3] = 1'b1;
      train_run();

      // second run, restarted from locked: no clean phase, shift too large, all clean, single phase
      cfg_pass[0] = 8'b0000_0000; cfg_d[0] = 0; exp_ph[0] = 0; exp_lk[0] = 1'b0;
      cfg_pass[1] = 8'b0110_0000; cfg_d[1] = 4; exp_ph[1] = 5; exp_lk[1] = 1'b0;
      cfg_pass[2] = 8'b1111_1111; cfg_d[2] = 1; exp_ph[2] = 3; exp_lk[2] = 1'b1;
      cfg_pass[3] = 8'b0100_0000; cfg_d[3] = 2; exp_ph[3] = 6; exp_lk[3] = 1'b1;
      train_run();

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #3000000;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule